// File: doc/BRIEF.md
# Dual-Nibble Permutation Absorb Unit

This block folds a stream of input bytes into a state array S that always holds a permutation of 0..N-1. The array has N entries, N is a power of two of at least 32, and the default is 256. Each byte is absorbed as two nibbles, low nibble first. Absorbing a nibble x exchanges the entry at the absorb pointer with the entry at N/2 + x, then advances the pointer by one. Both exchanges of a byte are done in one clock. An address-coincidence resolver turns the two dependent swaps into one set of simultaneous writes to the array.

The pointer must not pass the half-array mark H = N/2 without a shuffle of the whole array. The shuffle engine is outside this block. When the pointer reaches H, the unit raises a shuffle request and drops ready until a resume strobe arrives. The shuffle leaves the pointer at zero, so the unit clears the pointer itself on resume. It then finishes whatever part of the interrupted byte is still owed. A separate stop strobe absorbs the stop symbol, which advances the pointer by one and leaves S unchanged. A combinational peek port reads any array entry.

Top module: `nibble_pair_absorb`

## Requirements
- R1: Synchronous active-low reset sets S[v] = v for every v, clears the pointer, drives in_ready high and drives shuffle_req low.
- R2: When in_ready is high, in_valid is high and the pointer p satisfies p+1 < H, the byte is absorbed at the next edge. The result equals swapping S[p] with S[H+in_byte[3:0]] and then swapping S[p+1] with S[H+in_byte[7:4]], and p grows by 2.
- R3: When both nibbles are equal, both swaps target the same entry T. The result is S[p] = old S[T], S[p+1] = old S[p] and S[T] = old S[p+1].
- R4: A byte that arrives with p = H leaves S unchanged, sets shuffle_req high and sets in_ready low.
- R5: A byte that arrives with p+1 = H swaps only S[p] with S[H+low nibble] and raises shuffle_req. On resume, S[0] is swapped with S[H+high nibble] and the pointer becomes 1.
- R6: For a byte held at p = H, resume zeroes the pointer and absorbs the byte at positions 0 and 1 in the same edge, leaving the pointer at 2. shuffle_req falls and in_ready rises at that edge.
- R7: While shuffle_req is high, in_valid and in_stop are ignored. S does not change and nothing is absorbed later because of them.
- R8: resume while shuffle_req is low has no effect on S or on later absorption.
- R9: in_stop, when in_ready is high and in_valid is low, advances the pointer by one without writing S. With p = H it raises shuffle_req instead, and on resume the pointer becomes 1.
- R10: shuffle_req stays high on every edge until resume is sampled high.
- R11: peek_data equals S[peek_addr] in the same cycle, without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Byte to absorb; bits 3:0 are used first |
| in_stop | input | 1 | Absorb-stop strobe, taken only when in_valid is low |
| resume | input | 1 | External shuffle finished |
| in_ready | output | 1 | High when a byte or stop can be taken |
| shuffle_req | output | 1 | High while an external shuffle is awaited |
| peek_addr | input | clog2(N) | Array read address |
| peek_data | output | clog2(N) | Array entry at peek_addr |

## Verification
The bench goes after bytes with equal nibbles. A resolver that treated the shared target as two independent swaps would lose one array value and break the permutation. It also drives the pointer onto both half-array boundaries, an even one by bytes and an odd one reached through stop strobes. A design that mixed up these cases would swap while it should wait, or would drop or repeat the high nibble after resume. Stray bytes, stops and resumes are sent at the wrong moments to show that they cannot alter the array or move the pointer, and the pointer's position is revealed by where the next swaps land. Whole-array snapshots are compared with a model that applies the swaps strictly one after the other.

// File: rtl/nibble_pair_absorb_pkg.sv
// Shared types for the dual-nibble absorb unit.
// Assumes nothing beyond IEEE 1800-2017 enums.
package nibble_pair_absorb_pkg;

    // Address-coincidence class for two swaps (a1<->b1 then a2<->b2).
    typedef enum logic [2:0] {
        PAIR_DISJOINT  = 3'd0, // no coincidence
        PAIR_B_SHARED  = 3'd1, // b2 == b1
        PAIR_B2_IS_A1  = 3'd2, // b2 == a1
        PAIR_B2_A1_B1  = 3'd3, // b2 == a1 and b2 == b1
        PAIR_A2_IS_B1  = 3'd4, // a2 == b1
        PAIR_A2_B1_B2  = 3'd5, // a2 == b1 and b2 == b1
        PAIR_IDENTITY  = 3'd6, // a2 == b1 and b2 == a1: net no change
        PAIR_INVALID   = 3'd7  // cannot arise when a2 != a1
    } pair_case_e;

    // Controller state.
    typedef enum logic [1:0] {
        ABS_RUN       = 2'd0, // accepting input
        ABS_HOLD_FULL = 2'd1, // whole byte or stop owed after shuffle
        ABS_HOLD_HIGH = 2'd2  // high nibble owed after shuffle
    } absorb_state_e;

endpackage

// File: rtl/pair_swap_resolver.sv
// Turns two dependent swaps on one array into simultaneous writes.
// Inputs: four addresses and the values currently stored there.
// Output: up to four write ports whose combined effect equals doing
// a1<->b1 first and a2<->b2 second. In single mode only a1<->b1 is done.
// Assumes a1 != a2 whenever dual_en is high.
module pair_swap_resolver
    import nibble_pair_absorb_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual_en,
    input  logic          single_en,
    input  logic [AW-1:0] a1,
    input  logic [AW-1:0] a2,
    input  logic [AW-1:0] b1,
    input  logic [AW-1:0] b2,
    input  logic [AW-1:0] va1,
    input  logic [AW-1:0] va2,
    input  logic [AW-1:0] vb1,
    input  logic [AW-1:0] vb2,
    output logic [3:0]    wen,
    output logic [AW-1:0] waddr [4],
    output logic [AW-1:0] wdata [4]
);

    logic       eq_a2_b1;
    logic       eq_b2_a1;
    logic       eq_b2_b1;
    pair_case_e kind;

    // Classify how the two swaps overlap.
    always_comb begin
        eq_a2_b1 = (a2 == b1);
        eq_b2_a1 = (b2 == a1);
        eq_b2_b1 = (b2 == b1);
        case ({eq_a2_b1, eq_b2_a1, eq_b2_b1})
            3'b000:  kind = PAIR_DISJOINT;
            3'b001:  kind = PAIR_B_SHARED;
            3'b010:  kind = PAIR_B2_IS_A1;
            3'b011:  kind = PAIR_B2_A1_B1;
            3'b100:  kind = PAIR_A2_IS_B1;
            3'b101:  kind = PAIR_A2_B1_B2;
            3'b110:  kind = PAIR_IDENTITY;
            default: kind = PAIR_INVALID;
        endcase
    end

    // Select the register-to-register transfers for the chosen case.
    always_comb begin
        wen = 4'b0000;
        for (int p = 0; p < 4; p++) begin
            waddr[p] = '0;
            wdata[p] = '0;
        end
        if (single_en) begin
            wen      = 4'b0011;
            waddr[0] = a1; wdata[0] = vb1;
            waddr[1] = b1; wdata[1] = va1;
        end else if (dual_en) begin
            case (kind)
                PAIR_DISJOINT: begin
                    wen      = 4'b1111;
                    waddr[0] = b1; wdata[0] = va1;
                    waddr[1] = a1; wdata[1] = vb1;
                    waddr[2] = a2; wdata[2] = vb2;
                    waddr[3] = b2; wdata[3] = va2;
                end
                PAIR_B_SHARED: begin
                    wen      = 4'b0111;
                    waddr[0] = a2; wdata[0] = va1;
                    waddr[1] = b1; wdata[1] = va2;
                    waddr[2] = a1; wdata[2] = vb2;
                end
                PAIR_B2_IS_A1: begin
                    wen      = 4'b0111;
                    waddr[0] = b1; wdata[0] = va1;
                    waddr[1] = a1; wdata[1] = va2;
                    waddr[2] = a2; wdata[2] = vb1;
                end
                PAIR_B2_A1_B1: begin
                    wen      = 4'b0011;
                    waddr[0] = a2; wdata[0] = va1;
                    waddr[1] = a1; wdata[1] = va2;
                end
                PAIR_A2_IS_B1: begin
                    wen      = 4'b0111;
                    waddr[0] = b2; wdata[0] = va1;
                    waddr[1] = a2; wdata[1] = vb2;
                    waddr[2] = a1; wdata[2] = vb1;
                end
                PAIR_A2_B1_B2: begin
                    wen      = 4'b0011;
                    waddr[0] = a2; wdata[0] = va1;
                    waddr[1] = a1; wdata[1] = vb1;
                end
                default: wen = 4'b0000;
            endcase
        end
    end

    // R2: the controller never asks for both modes at once.
    assert_one_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(dual_en && single_en));

    // R3: the impossible coincidence class is never presented.
    assert_case_possible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dual_en |-> (kind != PAIR_INVALID));

endmodule

// File: rtl/perm_state_store.sv
// Register array holding the permutation S, N entries of AW bits.
// Reset loads the identity. NWP write ports, NRP combinational read
// ports. Assumes writers never send different data to one address.
module perm_state_store #(
    parameter int N   = 256,
    parameter int NWP = 4,
    parameter int NRP = 5,
    localparam int AW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NWP-1:0] wen,
    input  logic [AW-1:0]  waddr [NWP],
    input  logic [AW-1:0]  wdata [NWP],
    input  logic [AW-1:0]  raddr [NRP],
    output logic [AW-1:0]  rdata [NRP]
);

    logic [AW-1:0] mem [N];

    // Identity on reset, otherwise apply every enabled write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < N; e++) begin
                mem[e] <= AW'(e);
            end
        end else begin
            for (int p = 0; p < NWP; p++) begin
                if (wen[p]) begin
                    mem[waddr[p]] <= wdata[p];
                end
            end
        end
    end

    // One asynchronous read mux per read port.
    for (genvar r = 0; r < NRP; r++) begin : g_rd
        assign rdata[r] = mem[raddr[r]];
    end

    // R2: any two writes to one entry in a cycle must carry the same value.
    for (genvar p = 0; p < NWP; p++) begin : g_wa
        for (genvar q = p + 1; q < NWP; q++) begin : g_wb
            assert_write_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (wen[p] && wen[q] && (waddr[p] == waddr[q])) |-> (wdata[p] == wdata[q]));
        end
    end

endmodule

// File: rtl/absorb_sequencer.sv
// Absorb pointer and shuffle handshake. Picks swap addresses for the
// resolver: two nibble swaps per byte, one swap at the odd boundary,
// nothing at the even boundary. Waits for resume, then clears the
// pointer and finishes the owed part. Assumes N >= 32.
module absorb_sequencer
    import nibble_pair_absorb_pkg::*;
#(
    parameter int N   = 256,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    input  logic          in_stop,
    input  logic          resume,
    output logic          in_ready,
    output logic          shuffle_req,
    output logic          dual_en,
    output logic          single_en,
    output logic [AW-1:0] a1,
    output logic [AW-1:0] a2,
    output logic [AW-1:0] b1,
    output logic [AW-1:0] b2
);

    localparam logic [AW-1:0] HALF = AW'(N / 2);

    absorb_state_e st;
    logic [AW-1:0] ptr;
    logic [7:0]    pend_byte;
    logic          pend_stop;

    logic          take_byte;
    logic          take_stop;
    logic          at_half;
    logic          pre_half;
    logic          wake;

    // Decode accept conditions and boundary position.
    always_comb begin
        take_byte = (st == ABS_RUN) && in_valid;
        take_stop = (st == ABS_RUN) && in_stop && !in_valid;
        at_half   = (ptr == HALF);
        pre_half  = ((ptr + AW'(1)) == HALF);
        wake      = (st != ABS_RUN) && resume;
    end

    // Drive swap addresses and the resolver mode.
    always_comb begin
        dual_en   = 1'b0;
        single_en = 1'b0;
        a1 = ptr;
        a2 = ptr + AW'(1);
        b1 = HALF + AW'(in_byte[3:0]);
        b2 = HALF + AW'(in_byte[7:4]);
        if (take_byte && !at_half) begin
            dual_en   = !pre_half;
            single_en = pre_half;
        end else if (wake && st == ABS_HOLD_FULL) begin
            dual_en = !pend_stop;
            a1 = '0;
            a2 = AW'(1);
            b1 = HALF + AW'(pend_byte[3:0]);
            b2 = HALF + AW'(pend_byte[7:4]);
        end else if (wake && st == ABS_HOLD_HIGH) begin
            single_en = 1'b1;
            a1 = '0;
            b1 = HALF + AW'(pend_byte[7:4]);
        end
    end

    // Advance pointer and handshake state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ABS_RUN;
            ptr       <= '0;
            pend_byte <= '0;
            pend_stop <= 1'b0;
        end else if (take_byte) begin
            pend_byte <= in_byte;
            pend_stop <= 1'b0;
            if (at_half) begin
                st <= ABS_HOLD_FULL;
            end else if (pre_half) begin
                st  <= ABS_HOLD_HIGH;
                ptr <= ptr + AW'(1);
            end else begin
                ptr <= ptr + AW'(2);
            end
        end else if (take_stop) begin
            if (at_half) begin
                st        <= ABS_HOLD_FULL;
                pend_stop <= 1'b1;
            end else begin
                ptr <= ptr + AW'(1);
            end
        end else if (wake) begin
            st <= ABS_RUN;
            if (st == ABS_HOLD_FULL && !pend_stop) begin
                ptr <= AW'(2);
            end else begin
                ptr <= AW'(1);
            end
        end
    end

    // Ready and request come straight from the state register.
    always_comb begin
        in_ready    = (st == ABS_RUN);
        shuffle_req = (st != ABS_RUN);
    end

    // R2: the pointer never passes the half-array mark.
    assert_ptr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= HALF);

    // R10: a pending request is held until resume.
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (shuffle_req && !resume) |=> shuffle_req);

    // R6: resume releases the request and leaves the pointer at 1 or 2.
    assert_req_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shuffle_req && resume) |=> (!shuffle_req && (ptr == AW'(1) || ptr == AW'(2))));

    // R4: a request only starts from an offered byte or stop.
    assert_req_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shuffle_req) |-> $past(in_valid || in_stop));

    // R9: a stop away from the boundary advances the pointer by one.
    assert_stop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_stop && !in_valid && ptr != HALF) |=> (ptr == $past(ptr) + AW'(1)));

endmodule

// File: rtl/nibble_pair_absorb.sv
// Top: absorbs one byte per clock into the permutation S using two
// simultaneous nibble swaps, with a shuffle handshake at the half-array
// boundary and a combinational peek port. Assumes N is a power of two,
// N >= 32.
module nibble_pair_absorb #(
    parameter int N = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_byte,
    input  logic                 in_stop,
    input  logic                 resume,
    output logic                 in_ready,
    output logic                 shuffle_req,
    input  logic [$clog2(N)-1:0] peek_addr,
    output logic [$clog2(N)-1:0] peek_data
);

    localparam int AW  = $clog2(N);
    localparam int NWP = 4;
    localparam int NRP = 5;

    logic          dual_en;
    logic          single_en;
    logic [AW-1:0] a1, a2, b1, b2;
    logic [AW-1:0] raddr [NRP];
    logic [AW-1:0] rdata [NRP];
    logic [NWP-1:0] wen;
    logic [AW-1:0] waddr [NWP];
    logic [AW-1:0] wdata [NWP];

    absorb_sequencer #(.N(N)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_byte(in_byte), .in_stop(in_stop), .resume(resume),
        .in_ready(in_ready), .shuffle_req(shuffle_req),
        .dual_en(dual_en), .single_en(single_en),
        .a1(a1), .a2(a2), .b1(b1), .b2(b2)
    );

    // Route swap addresses and the peek address to the read ports.
    always_comb begin
        raddr[0] = a1;
        raddr[1] = a2;
        raddr[2] = b1;
        raddr[3] = b2;
        raddr[4] = peek_addr;
        peek_data = rdata[4];
    end

    pair_swap_resolver #(.AW(AW)) u_res (
        .clk(clk), .rst_n(rst_n),
        .dual_en(dual_en), .single_en(single_en),
        .a1(a1), .a2(a2), .b1(b1), .b2(b2),
        .va1(rdata[0]), .va2(rdata[1]), .vb1(rdata[2]), .vb2(rdata[3]),
        .wen(wen), .waddr(waddr), .wdata(wdata)
    );

    perm_state_store #(.N(N), .NWP(NWP), .NRP(NRP)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wen(wen), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );

    // R7: no array write while a shuffle is awaited, except on resume.
    assert_quiet_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shuffle_req && !resume) |-> (wen == '0));

endmodule

// File: tb/tb_nibble_pair_absorb.sv
// Scoreboard bench: driver tasks update a sequential swap model and
// queue expected array entries; a monitor reads them via the peek port.
module tb_nibble_pair_absorb;

    localparam int  N  = 256;
    localparam int  H  = N / 2;
    localparam int  AW = $clog2(N);
    localparam time CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic          in_stop = 1'b0;
    logic          resume = 1'b0;
    logic          in_ready;
    logic          shuffle_req;
    logic [AW-1:0] peek_addr = '0;
    logic [AW-1:0] peek_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nibble_pair_absorb #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_byte(in_byte), .in_stop(in_stop), .resume(resume),
        .in_ready(in_ready), .shuffle_req(shuffle_req),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );

    typedef struct {
        int    addr;
        int    val;
        string req;
    } exp_t;

    exp_t  q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    int    model[N];
    int    m_ptr;
    int    m_wait;       // 0 run, 1 whole byte/stop owed, 2 high nibble owed
    int    m_pend;
    bit    m_pend_stop;
    logic [7:0] lf = 8'h1D;

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void mswap(int x, int y);
        int t;
        t = model[x];
        model[x] = model[y];
        model[y] = t;
    endfunction

    function automatic logic [7:0] next_lf();
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        return lf;
    endfunction

    // Monitor: R11 peek port compared entry by entry against the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                peek_addr = AW'(e.addr);
                #1;
                chk(e.req, int'(peek_data), e.val);
            end
        end
    end

    task automatic snapshot(string req);
        for (int v = 0; v < N; v++) begin
            q.push_back('{v, model[v], req});
        end
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic chk_flags(string req);
        chk({req, " in_ready"}, int'(in_ready), (m_wait == 0) ? 1 : 0);
        chk({req, " shuffle_req"}, int'(shuffle_req), (m_wait != 0) ? 1 : 0);
    endtask

    // Driver: one byte; model applies the two swaps one after the other.
    task automatic send_byte(logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        if (m_wait == 0) begin
            if (m_ptr == H) begin
                m_wait = 1; m_pend = b; m_pend_stop = 1'b0;
            end else if (m_ptr + 1 == H) begin
                mswap(m_ptr, H + b[3:0]);
                m_ptr++;
                m_wait = 2; m_pend = b;
            end else begin
                mswap(m_ptr, H + b[3:0]);
                mswap(m_ptr + 1, H + b[7:4]);
                m_ptr += 2;
            end
        end
    endtask

    task automatic send_stop();
        @(negedge clk);
        in_stop = 1'b1;
        @(negedge clk);
        in_stop = 1'b0;
        if (m_wait == 0) begin
            if (m_ptr == H) begin
                m_wait = 1; m_pend_stop = 1'b1;
            end else begin
                m_ptr++;
            end
        end
    endtask

    task automatic pulse_resume();
        @(negedge clk);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        if (m_wait != 0) begin
            m_ptr = 0;
            if (m_wait == 1) begin
                if (m_pend_stop) begin
                    m_ptr = 1;
                end else begin
                    mswap(0, H + m_pend[3:0]);
                    mswap(1, H + m_pend[7:4]);
                    m_ptr = 2;
                end
            end else begin
                mswap(0, H + m_pend[7:4]);
                m_ptr = 1;
            end
            m_wait = 0;
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        for (int v = 0; v < N; v++) model[v] = v;
        m_ptr = 0; m_wait = 0; m_pend = 0; m_pend_stop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_flags("R1");
        snapshot("R1 identity");

        // R2 and R3: equal nibbles (shared target), then mixed patterns
        send_byte(8'h00);
        send_byte(8'h77);
        snapshot("R3 shared target");
        send_byte(8'hA5);
        send_byte(8'h5A);
        send_byte(8'hF0);
        send_byte(8'h0F);
        snapshot("R2 mixed bytes");
        while (m_ptr < H) send_byte(next_lf());
        snapshot("R2 up to boundary");

        // R4: byte at the even boundary only requests a shuffle
        send_byte(8'h3C);
        chk_flags("R4");
        snapshot("R4 no swap");

        // R10: request held across idle cycles
        repeat (6) @(negedge clk);
        chk("R10 held", int'(shuffle_req), 1);

        // R7: inputs ignored while waiting
        send_byte(8'hE1);
        send_stop();
        chk_flags("R7");
        snapshot("R7 untouched");

        // R6: resume absorbs the held byte at positions 0 and 1
        pulse_resume();
        chk_flags("R6");
        snapshot("R6 held byte");

        // R8: resume with no request pending
        pulse_resume();
        chk_flags("R8");
        send_byte(8'h2B);
        snapshot("R8 stray resume");

        // R9 and R5: stop makes the pointer odd, reach the odd boundary
        send_stop();
        snapshot("R9 stop no write");
        while (m_ptr + 1 < H) send_byte(next_lf());
        send_byte(8'h9E);
        chk_flags("R5");
        snapshot("R5 low nibble only");
        pulse_resume();
        chk_flags("R5 resumed");
        snapshot("R5 high nibble at 0");

        // R9: stop at the even boundary, resume leaves pointer at 1
        send_stop();
        while (m_ptr < H) send_byte(next_lf());
        send_stop();
        chk_flags("R9 stop at boundary");
        snapshot("R9 no write");
        pulse_resume();
        chk_flags("R9 resumed");
        send_byte(8'h4B);
        send_byte(8'hCC);
        snapshot("R9 pointer after resume");

        report();
        $finish;
    end

endmodule